// File: doc/BRIEF.md
# Five-Sample Optimal Filter Engine

This block turns the digitized pulse of one calorimeter channel into three physics results. For every channel of an accepted event, five consecutive time samples arrive, one per clock, tagged with the channel number and the sample position. Each sample first has a per-channel baseline removed and is then scaled by a per-channel gain. Two weighted sums of the five corrected samples follow, using per-channel weights. The first sum is the deposited energy. The second, divided by the energy, is the deposition time. A chi-square residual against a stored per-channel pulse shape, scaled by the energy, measures pulse-shape quality.

All per-channel constants, and one global energy threshold, are written through a simple address/data configuration port. Channels may follow one another with no gap. A full event of 128 channels therefore takes 640 clocks. The block emits one result per channel, in the order the channels arrived, with a valid strobe. When the energy does not exceed the threshold, the time output is forced to zero and flagged invalid, so the block never divides by a small or zero energy.

Top module: `optfilt5`

## Requirements
- R1: While reset is low, and in the first cycle after it, `out_valid` is 0.
- R2: Each sample s is corrected as c = ((s − pedestal) × gain) >>> 12. The pedestal is unsigned, the gain is signed with 12 fractional bits, and the shift is arithmetic.
- R3: Energy E = (Σ aᵢ·cᵢ) >>> 12, with signed weights a₀..a₄ having 12 fractional bits. `out_energy` is E saturated to signed 32 bits.
- R4: When E > threshold (the threshold compared as a non-negative value), `out_tvalid` is 1 and `out_time` is (P·256)/E. Here P = (Σ bᵢ·cᵢ) >>> 12, the division truncates toward zero, and the result is saturated to signed 16 bits.
- R5: When E ≤ threshold, including negative E and E exactly equal to the threshold, `out_tvalid` is 0 and `out_time` is 0.
- R6: Each chi-square term is dᵢ² with dᵢ = cᵢ − ((E·gᵢ) >>> 12). A term with |dᵢ| ≥ 65536 counts as 2³²−1. `out_chi2` is the sum saturated at 2³²−1.
- R7: A result appears exactly two clocks after the clock that samples the beat with `in_idx` = 4. Results come one per channel, in arrival order, with `out_chan` equal to that channel. No `out_valid` occurs otherwise.
- R8: A write with `cfg_we` = 1 stores `cfg_data` into the field of channel `cfg_chan` chosen by `cfg_sel`. The codes are: 0 pedestal, 1 gain, 2..6 weights a₀..a₄, 7..11 weights b₀..b₄, 12..16 shape g₀..g₄, and 31 the global threshold, which ignores `cfg_chan`. Later events use the new value.
- R9: Channels may follow one another with no idle cycle, at one sample per clock, and every channel still yields a correct result.
- R10: Cycles with `in_valid` = 0 between the samples of a channel do not change that channel's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_chan | input | 7 | Channel whose constant is written |
| cfg_sel | input | 5 | Field select code (see R8) |
| cfg_data | input | 16 | Value written |
| in_valid | input | 1 | Sample beat valid |
| in_chan | input | 7 | Channel of the sample |
| in_idx | input | 3 | Sample position 0..4 within the channel |
| in_sample | input | 16 | Unsigned digitized sample |
| out_valid | output | 1 | Result strobe |
| out_chan | output | 7 | Channel of the result |
| out_energy | output | 32 | Signed energy |
| out_time | output | 16 | Signed time in 1/256 units, 0 when invalid |
| out_tvalid | output | 1 | Time is meaningful |
| out_chi2 | output | 32 | Saturated pulse-shape residual |

## Verification
The hardest cases to reach from the ports are energy landing exactly on the threshold and a chi-square term crossing its saturation limit. Random pulses almost never produce either. The stimulus reaches both by reprogramming one channel to an identity setup: zero pedestal, unit gain, and a single-tap energy weight. With that setup the energy equals one chosen sample, so it can be placed at the threshold, one above it, below zero, or next to a huge timing sum. Doubling the gain while setting the shape to zero then pushes corrected samples past the per-term limit. A behavioural model predicts every output cycle by cycle, both during these directed cases and during a full 128-channel back-to-back event with gaps.

// File: rtl/optfilt_pkg.sv
// Shared configuration field codes for the optimal filter engine.
package optfilt_pkg;
    localparam int SEL_W = 5;
    localparam logic [SEL_W-1:0] SEL_PED   = 5'd0;
    localparam logic [SEL_W-1:0] SEL_GAIN  = 5'd1;
    localparam logic [SEL_W-1:0] SEL_COEF0 = 5'd2;
    localparam logic [SEL_W-1:0] SEL_THR   = 5'd31;
endpackage

// File: rtl/of_coef_mem.sv
// Per-channel constant store. Holds the pedestal, gain and three weight sets
// per channel, plus one global threshold. Reads are asynchronous.
// Assumes constants are not rewritten while an event is in flight and NS <= 9.
module of_coef_mem
    import optfilt_pkg::*;
#(
    parameter int N_CHAN = 128,
    parameter int NS     = 5,
    parameter int CW     = 16,
    parameter int CH_W   = $clog2(N_CHAN),
    parameter int IDX_W  = $clog2(NS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_we,
    input  logic [CH_W-1:0]        cfg_chan,
    input  logic [SEL_W-1:0]       cfg_sel,
    input  logic [CW-1:0]          cfg_data,
    input  logic [CH_W-1:0]        rda_chan,
    output logic [CW-1:0]          ped,
    output logic [CW-1:0]          gain,
    input  logic [CH_W-1:0]        rdb_chan,
    input  logic [IDX_W-1:0]       rdb_idx,
    output logic [CW-1:0]          coef_a,
    output logic [CW-1:0]          coef_b,
    input  logic [CH_W-1:0]        rdc_chan,
    output logic [NS-1:0][CW-1:0]  shape,
    output logic [CW-1:0]          thr
);
    logic [CW-1:0] m_ped  [N_CHAN];
    logic [CW-1:0] m_gain [N_CHAN];
    logic [CW-1:0] m_a    [N_CHAN][NS];
    logic [CW-1:0] m_b    [N_CHAN][NS];
    logic [CW-1:0] m_g    [N_CHAN][NS];

    // Decode a configuration write into the per-channel tables.
    always_ff @(posedge clk) begin
        if (cfg_we) begin
            if (cfg_sel == SEL_PED)  m_ped[cfg_chan]  <= cfg_data;
            if (cfg_sel == SEL_GAIN) m_gain[cfg_chan] <= cfg_data;
            for (int k = 0; k < NS; k++) begin
                if (cfg_sel == SEL_W'(int'(SEL_COEF0) + k))          m_a[cfg_chan][k] <= cfg_data;
                if (cfg_sel == SEL_W'(int'(SEL_COEF0) + NS + k))     m_b[cfg_chan][k] <= cfg_data;
                if (cfg_sel == SEL_W'(int'(SEL_COEF0) + 2 * NS + k)) m_g[cfg_chan][k] <= cfg_data;
            end
        end
    end

    // Global energy threshold, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                            thr <= '0;
        else if (cfg_we && cfg_sel == SEL_THR) thr <= cfg_data;
    end

    assign ped    = m_ped[rda_chan];
    assign gain   = m_gain[rda_chan];
    assign coef_a = m_a[rdb_chan][rdb_idx];
    assign coef_b = m_b[rdb_chan][rdb_idx];

    for (genvar k = 0; k < NS; k++) begin : g_shape
        assign shape[k] = m_g[rdc_chan][k];
    end
endmodule

// File: rtl/of_accum.sv
// Calibration and weighted-sum stages. Stage A corrects each sample with the
// channel's pedestal and gain. Stage B accumulates both weighted sums and keeps
// the corrected samples. Assumes a channel's beats arrive in index order 0..NS-1.
module of_accum #(
    parameter int NS     = 5,
    parameter int SAMP_W = 16,
    parameter int CW     = 16,
    parameter int FRAC   = 12,
    parameter int CH_W   = 7,
    parameter int IDX_W  = 3,
    parameter int PW     = SAMP_W + 1 + CW,
    parameter int ACC_W  = PW + CW + 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    input  logic [CH_W-1:0]             in_chan,
    input  logic [IDX_W-1:0]            in_idx,
    input  logic [SAMP_W-1:0]           in_sample,
    input  logic [CW-1:0]               ped,
    input  logic [CW-1:0]               gain,
    input  logic [CW-1:0]               coef_a,
    input  logic [CW-1:0]               coef_b,
    output logic [CH_W-1:0]             st_chan,
    output logic [IDX_W-1:0]            st_idx,
    output logic                        done,
    output logic [CH_W-1:0]             done_chan,
    output logic signed [ACC_W-1:0]     acc_e,
    output logic signed [ACC_W-1:0]     acc_p,
    output logic [NS-1:0][PW-1:0]       cbuf
);
    logic                  v_r;
    logic signed [PW-1:0]  c_r;
    logic signed [SAMP_W:0] diff;
    logic signed [PW-1:0]  prod, c_next;
    logic signed [ACC_W-1:0] pe, pb;

    assign diff   = $signed({1'b0, in_sample}) - $signed({1'b0, ped});
    assign prod   = PW'(diff) * PW'($signed(gain));
    assign c_next = prod >>> FRAC;
    assign pe     = ACC_W'(c_r) * ACC_W'($signed(coef_a));
    assign pb     = ACC_W'(c_r) * ACC_W'($signed(coef_b));

    // Stage A: register the calibrated sample with its tags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_r <= 1'b0; st_chan <= '0; st_idx <= '0; c_r <= '0;
        end else begin
            v_r     <= in_valid;
            st_chan <= in_chan;
            st_idx  <= in_idx;
            c_r     <= c_next;
        end
    end

    // Stage B: accumulate both sums and flag the last beat of a channel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done <= 1'b0; done_chan <= '0; acc_e <= '0; acc_p <= '0; cbuf <= '0;
        end else begin
            done <= v_r && (st_idx == IDX_W'(NS - 1));
            if (v_r) begin
                acc_e          <= (st_idx == '0) ? pe : acc_e + pe;
                acc_p          <= (st_idx == '0) ? pb : acc_p + pb;
                cbuf[st_idx]   <= c_r;
                done_chan      <= st_chan;
            end
        end
    end
endmodule

// File: rtl/of_finish.sv
// Result stage. It scales the sums, guards and performs the time division,
// forms the saturated chi-square residual and registers the result word.
// Assumes its inputs are stable during the cycle in which done is high.
module of_finish #(
    parameter int NS    = 5,
    parameter int CW    = 16,
    parameter int FRAC  = 12,
    parameter int TSH   = 8,
    parameter int PW    = 33,
    parameter int ACC_W = 53,
    parameter int CH_W  = 7,
    parameter int E_W   = 32,
    parameter int T_W   = 16,
    parameter int Q_W   = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    done,
    input  logic [CH_W-1:0]         done_chan,
    input  logic signed [ACC_W-1:0] acc_e,
    input  logic signed [ACC_W-1:0] acc_p,
    input  logic [NS-1:0][PW-1:0]   cbuf,
    input  logic [NS-1:0][CW-1:0]   shape,
    input  logic [CW-1:0]           thr,
    output logic                    out_valid,
    output logic [CH_W-1:0]         out_chan,
    output logic [E_W-1:0]          out_energy,
    output logic [T_W-1:0]          out_time,
    output logic                    out_tvalid,
    output logic [Q_W-1:0]          out_chi2
);
    localparam int MW    = ACC_W + CW;
    localparam int HALF  = Q_W / 2;
    localparam int SUM_W = Q_W + $clog2(NS) + 1;
    localparam logic signed [ACC_W-1:0] E_MAX = ACC_W'((64'sd1 <<< (E_W - 1)) - 64'sd1);
    localparam logic signed [ACC_W-1:0] E_MIN = -E_MAX - ACC_W'(1);
    localparam logic signed [ACC_W-1:0] T_MAX = ACC_W'((64'sd1 <<< (T_W - 1)) - 64'sd1);
    localparam logic signed [ACC_W-1:0] T_MIN = -T_MAX - ACC_W'(1);

    logic signed [ACC_W-1:0] e_full, p_full, thr_s, den, quo;
    logic                    tval;
    logic [E_W-1:0]          e_sat;
    logic [T_W-1:0]          t_sat;
    logic [Q_W-1:0]          term [NS];
    logic [SUM_W-1:0]        sum;
    logic [Q_W-1:0]          chi;

    assign e_full = acc_e >>> FRAC;
    assign p_full = acc_p >>> FRAC;
    assign thr_s  = ACC_W'($signed({1'b0, thr}));
    assign tval   = e_full > thr_s;
    assign den    = tval ? e_full : ACC_W'(1);
    assign quo    = (p_full <<< TSH) / den;
    assign e_sat  = (e_full > E_MAX) ? E_W'(E_MAX) : (e_full < E_MIN) ? E_W'(E_MIN) : E_W'(e_full);
    assign t_sat  = !tval ? '0 : (quo > T_MAX) ? T_W'(T_MAX) : (quo < T_MIN) ? T_W'(T_MIN) : T_W'(quo);

    for (genvar k = 0; k < NS; k++) begin : g_term
        logic signed [MW-1:0] fit, dif;
        logic [MW-1:0]        mag;
        assign fit     = (MW'(e_full) * MW'($signed(shape[k]))) >>> FRAC;
        assign dif     = MW'($signed(cbuf[k])) - fit;
        assign mag     = dif[MW-1] ? MW'(-dif) : MW'(dif);
        assign term[k] = (|mag[MW-1:HALF]) ? '1 : Q_W'(mag[HALF-1:0]) * Q_W'(mag[HALF-1:0]);
    end

    // Add the per-sample terms and saturate the total.
    always_comb begin
        sum = '0;
        for (int k = 0; k < NS; k++) sum = sum + SUM_W'(term[k]);
        chi = (|sum[SUM_W-1:Q_W]) ? '1 : sum[Q_W-1:0];
    end

    // Register the result word when a channel completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0; out_chan <= '0; out_energy <= '0;
            out_time <= '0; out_tvalid <= 1'b0; out_chi2 <= '0;
        end else begin
            out_valid <= done;
            if (done) begin
                out_chan   <= done_chan;
                out_energy <= e_sat;
                out_time   <= t_sat;
                out_tvalid <= tval;
                out_chi2   <= chi;
            end
        end
    end
endmodule

// File: rtl/optfilt5.sv
// Five-sample optimal filter engine, top level. Takes one calibrated-to-be
// sample per clock and produces energy, time and chi-square per channel two
// clocks after the channel's last sample. Assumes beats of one channel are
// contiguous in index order; idle cycles between them are allowed.
module optfilt5 #(
    parameter int N_CHAN = 128,
    parameter int NS     = 5,
    parameter int SAMP_W = 16,
    parameter int CW     = 16,
    parameter int FRAC   = 12,
    parameter int TSH    = 8,
    parameter int E_W    = 32,
    parameter int T_W    = 16,
    parameter int Q_W    = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cfg_we,
    input  logic [$clog2(N_CHAN)-1:0]   cfg_chan,
    input  logic [4:0]                  cfg_sel,
    input  logic [CW-1:0]               cfg_data,
    input  logic                        in_valid,
    input  logic [$clog2(N_CHAN)-1:0]   in_chan,
    input  logic [$clog2(NS)-1:0]       in_idx,
    input  logic [SAMP_W-1:0]           in_sample,
    output logic                        out_valid,
    output logic [$clog2(N_CHAN)-1:0]   out_chan,
    output logic [E_W-1:0]              out_energy,
    output logic [T_W-1:0]              out_time,
    output logic                        out_tvalid,
    output logic [Q_W-1:0]              out_chi2
);
    localparam int CH_W  = $clog2(N_CHAN);
    localparam int IDX_W = $clog2(NS);
    localparam int PW    = SAMP_W + 1 + CW;
    localparam int ACC_W = PW + CW + 4;

    logic [CW-1:0]              ped, gain, coef_a, coef_b, thr;
    logic [NS-1:0][CW-1:0]      shape;
    logic [CH_W-1:0]            st_chan, done_chan;
    logic [IDX_W-1:0]           st_idx;
    logic                       done;
    logic signed [ACC_W-1:0]    acc_e, acc_p;
    logic [NS-1:0][PW-1:0]      cbuf;

    of_coef_mem #(.N_CHAN(N_CHAN), .NS(NS), .CW(CW), .CH_W(CH_W), .IDX_W(IDX_W)) u_mem (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_chan(cfg_chan), .cfg_sel(cfg_sel),
        .cfg_data(cfg_data), .rda_chan(in_chan), .ped(ped), .gain(gain),
        .rdb_chan(st_chan), .rdb_idx(st_idx), .coef_a(coef_a), .coef_b(coef_b),
        .rdc_chan(done_chan), .shape(shape), .thr(thr)
    );

    of_accum #(.NS(NS), .SAMP_W(SAMP_W), .CW(CW), .FRAC(FRAC), .CH_W(CH_W),
               .IDX_W(IDX_W), .PW(PW), .ACC_W(ACC_W)) u_acc (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_chan(in_chan), .in_idx(in_idx),
        .in_sample(in_sample), .ped(ped), .gain(gain), .coef_a(coef_a), .coef_b(coef_b),
        .st_chan(st_chan), .st_idx(st_idx), .done(done), .done_chan(done_chan),
        .acc_e(acc_e), .acc_p(acc_p), .cbuf(cbuf)
    );

    of_finish #(.NS(NS), .CW(CW), .FRAC(FRAC), .TSH(TSH), .PW(PW), .ACC_W(ACC_W),
                .CH_W(CH_W), .E_W(E_W), .T_W(T_W), .Q_W(Q_W)) u_fin (
        .clk(clk), .rst_n(rst_n), .done(done), .done_chan(done_chan), .acc_e(acc_e),
        .acc_p(acc_p), .cbuf(cbuf), .shape(shape), .thr(thr), .out_valid(out_valid),
        .out_chan(out_chan), .out_energy(out_energy), .out_time(out_time),
        .out_tvalid(out_tvalid), .out_chi2(out_chi2)
    );
endmodule

// File: rtl/of_check.sv
// Protocol and result-consistency assertions for optfilt5, attached by bind.
// Assumes inputs are held idle while reset is low.
module of_check #(
    parameter int NS    = 5,
    parameter int CH_W  = 7,
    parameter int IDX_W = 3,
    parameter int E_W   = 32,
    parameter int T_W   = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [IDX_W-1:0] in_idx,
    input logic [CH_W-1:0]  in_chan,
    input logic             out_valid,
    input logic [CH_W-1:0]  out_chan,
    input logic             out_tvalid,
    input logic [T_W-1:0]   out_time,
    input logic [E_W-1:0]   out_energy
);
    logic [1:0] since_rst;

    // Count clocks since reset, saturating at three, to bound $past depth.
    always_ff @(posedge clk) begin
        if (!rst_n)               since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    a_r1_idle_in_reset: assert property (@(posedge clk) !rst_n |=> !out_valid);

    a_r7_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd3 && out_valid) |-> $past(in_valid && in_idx == IDX_W'(NS - 1), 3));

    a_r7_result_due: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd3 && in_valid && in_idx == IDX_W'(NS - 1)) |-> ##3 out_valid);

    a_r7_chan_order: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd3 && out_valid) |-> out_chan == $past(in_chan, 3));

    a_r5_time_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_tvalid) |-> out_time == '0);

    a_r4_positive_energy: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_tvalid) |-> (!out_energy[E_W-1] && out_energy != '0));
endmodule

bind optfilt5 of_check #(.NS(NS), .CH_W(CH_W), .IDX_W(IDX_W), .E_W(E_W), .T_W(T_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_idx(in_idx), .in_chan(in_chan),
    .out_valid(out_valid), .out_chan(out_chan), .out_tvalid(out_tvalid),
    .out_time(out_time), .out_energy(out_energy)
);

// File: tb/sim_optfilt5.sv
// Bench for optfilt5: behavioural reference model compared on every clock.
module sim_optfilt5;
    localparam int CLK_P = 10;
    localparam int NCH   = 128;
    localparam longint QMAX = 64'd4294967295;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [6:0]  cfg_chan = '0;
    logic [4:0]  cfg_sel = '0;
    logic [15:0] cfg_data = '0;
    logic        in_valid = 1'b0;
    logic [6:0]  in_chan = '0;
    logic [2:0]  in_idx = '0;
    logic [15:0] in_sample = '0;
    logic        out_valid, out_tvalid;
    logic [6:0]  out_chan;
    logic [31:0] out_energy, out_chi2;
    logic [15:0] out_time;

    int total = 0;
    int bad = 0;
    longint cyc = 0;

    optfilt5 u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_chan(cfg_chan), .cfg_sel(cfg_sel),
        .cfg_data(cfg_data), .in_valid(in_valid), .in_chan(in_chan), .in_idx(in_idx),
        .in_sample(in_sample), .out_valid(out_valid), .out_chan(out_chan),
        .out_energy(out_energy), .out_time(out_time), .out_tvalid(out_tvalid),
        .out_chi2(out_chi2)
    );

    always #(CLK_P / 2) clk = ~clk;

    // Mirror of the programmed constants.
    longint bped [NCH];
    longint bgain [NCH];
    longint ba [NCH][5];
    longint bb [NCH][5];
    longint bg [NCH][5];
    longint bthr = 0;

    typedef struct {
        longint due;
        int     chan;
        longint e;
        longint t;
        bit     tv;
        longint chi;
    } exp_t;
    exp_t q[$];
    longint ms [5];

    function automatic longint clampv(longint v, longint lo, longint hi);
        return (v > hi) ? hi : (v < lo) ? lo : v;
    endfunction

    // Expected result of one channel from the requirement formulas.
    function automatic exp_t predict(int ch);
        exp_t r;
        longint c [5];
        longint ae = 0, ap = 0, e, p, s = 0;
        for (int i = 0; i < 5; i++) begin
            c[i] = ((ms[i] - bped[ch]) * bgain[ch]) >>> 12;
            ae += ba[ch][i] * c[i];
            ap += bb[ch][i] * c[i];
        end
        e = ae >>> 12;
        p = ap >>> 12;
        r.chan = ch;
        r.e  = clampv(e, -64'sd2147483648, 64'sd2147483647);
        r.tv = (e > bthr);
        r.t  = r.tv ? clampv((p * 256) / e, -32768, 32767) : 0;
        for (int i = 0; i < 5; i++) begin
            longint d, ad;
            d  = c[i] - ((e * bg[ch][i]) >>> 12);
            ad = (d < 0) ? -d : d;
            s += (ad >= 65536) ? QMAX : ad * ad;
        end
        r.chi = (s > QMAX) ? QMAX : s;
        return r;
    endfunction

    // Reference model: capture beats at the edge and schedule results.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst_n) begin
            q.delete();
        end else if (in_valid) begin
            ms[in_idx] = longint'(in_sample);
            if (in_idx == 3'd4) begin
                exp_t r;
                r = predict(int'(in_chan));
                r.due = cyc + 2;
                q.push_back(r);
            end
        end
    end

    task automatic chk(bit ok, string req, longint act, longint expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // Compare outputs away from the active edge, every cycle.
    always @(negedge clk) begin
        if (rst_n) begin
            if (q.size() > 0 && q[0].due == cyc - 1) begin
                exp_t r;
                r = q.pop_front();
                chk(out_valid == 1'b1, "R7 valid", longint'(out_valid), 1);
                chk(out_chan == 7'(r.chan), "R7 chan", longint'(out_chan), r.chan);
                chk(out_energy == 32'(r.e), "R3 energy (R2 calib)", longint'($signed(out_energy)), r.e);
                chk(out_tvalid == r.tv, r.tv ? "R4 tvalid" : "R5 tvalid", longint'(out_tvalid), longint'(r.tv));
                chk(out_time == 16'(r.t), r.tv ? "R4 time" : "R5 time", longint'($signed(out_time)), r.t);
                chk(out_chi2 == 32'(r.chi), "R6 chi2", longint'(out_chi2), r.chi);
            end else if (out_valid) begin
                chk(1'b0, "R7 unexpected valid", 1, 0);
            end
        end
    end

    task automatic cfg(int ch, int sel, longint val);
        @(negedge clk);
        in_valid = 1'b0;
        cfg_we = 1'b1; cfg_chan = 7'(ch); cfg_sel = 5'(sel); cfg_data = 16'(val);
        if (sel == 0) bped[ch] = val & 16'hFFFF;
        else if (sel == 1) bgain[ch] = val;
        else if (sel >= 2 && sel <= 6) ba[ch][sel-2] = val;
        else if (sel >= 7 && sel <= 11) bb[ch][sel-7] = val;
        else if (sel >= 12 && sel <= 16) bg[ch][sel-12] = val;
        else if (sel == 31) bthr = val & 16'hFFFF;
    endtask

    task automatic idle(int n);
        repeat (n) begin
            @(negedge clk);
            cfg_we = 1'b0; in_valid = 1'b0;
        end
    endtask

    task automatic send(int ch, longint s0, longint s1, longint s2, longint s3, longint s4, int gap);
        longint s [5];
        s = '{s0, s1, s2, s3, s4};
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            cfg_we = 1'b0;
            in_valid = 1'b1; in_chan = 7'(ch); in_idx = 3'(i); in_sample = 16'(s[i]);
            if (gap > 0) idle(gap);
        end
    endtask

    // Identity channel: zero pedestal, unit gain, energy equals sample 0.
    task automatic set_ident(int ch, longint gn, longint b1, longint gsh);
        cfg(ch, 0, 0);
        cfg(ch, 1, gn);
        for (int i = 0; i < 5; i++) begin
            cfg(ch, 2 + i, (i == 0) ? 4096 : 0);
            cfg(ch, 7 + i, (i == 1) ? b1 : 0);
            cfg(ch, 12 + i, gsh);
        end
    endtask

    initial begin
        longint shp [5];
        shp = '{300, 2900, 4096, 2600, 1000};
        // R1: reset state.
        idle(3);
        chk(out_valid == 1'b0, "R1 valid in reset", longint'(out_valid), 0);
        @(negedge clk); rst_n = 1'b1;
        chk(out_valid == 1'b0, "R1 valid after reset", longint'(out_valid), 0);

        // R8: program every channel with distinct constants.
        cfg(0, 31, 50);
        for (int ch = 0; ch < NCH; ch++) begin
            cfg(ch, 0, 150 + (ch % 60));
            cfg(ch, 1, 4096 + (ch % 16) * 96 - 700);
            for (int i = 0; i < 5; i++) begin
                cfg(ch, 2 + i, shp[i] / 4 + ((ch * 7 + i * 13) % 200) - 100);
                cfg(ch, 7 + i, (i - 2) * 700 + (ch % 9) * 20);
                cfg(ch, 12 + i, shp[i]);
            end
        end

        // R9: full event, 128 channels back to back, pulse-like samples.
        for (int ch = 0; ch < NCH; ch++) begin
            longint amp, pd;
            amp = (ch % 11 == 0) ? longint'($urandom_range(0, 30)) : longint'($urandom_range(40, 12000));
            pd  = 150 + (ch % 60);
            send(ch, pd + amp * shp[0] / 4096 + $urandom_range(0, 8),
                     pd + amp * shp[1] / 4096 + $urandom_range(0, 8),
                     pd + amp * shp[2] / 4096 + $urandom_range(0, 8),
                     pd + amp * shp[3] / 4096 + $urandom_range(0, 8),
                     pd + amp * shp[4] / 4096 + $urandom_range(0, 8), 0);
        end
        idle(4);

        // R10: idle gaps between the samples of one channel.
        send(3, 5000, 9000, 12000, 8000, 3000, 2);
        send(77, 200, 60000, 300, 40000, 100, 1);
        idle(4);

        // R5/R4 boundary: energy exactly at, and one above, the threshold.
        set_ident(5, 4096, 4096, 4096);
        cfg(0, 31, 1000);
        send(5, 1000, 700, 10, 20, 30, 0);
        send(5, 1001, 700, 10, 20, 30, 0);
        idle(4);

        // R5: negative energy with a nonzero pedestal.
        cfg(5, 0, 2000);
        send(5, 0, 2500, 2000, 2000, 2000, 0);
        idle(4);

        // R4: time saturation with threshold zero and energy one.
        cfg(5, 0, 0);
        cfg(0, 31, 0);
        set_ident(6, 4096, 32767, 0);
        send(6, 1, 60000, 0, 0, 0, 0);
        cfg(6, 8, -32768);
        send(6, 1, 60000, 0, 0, 0, 0);
        idle(4);

        // R6: chi-square terms just under and over the per-term limit.
        set_ident(7, 4096, 0, 0);
        send(7, 65535, 65535, 0, 0, 0, 0);
        send(7, 0, 100, 200, 300, 400, 0);
        cfg(7, 1, 8192);
        send(7, 40000, 65535, 1, 2, 3, 0);
        idle(6);

        chk(q.size() == 0, "R7 results outstanding", q.size(), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 100000, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule